// File: doc/BRIEF.md
# ADC Sample Formatter and Word Packer

This block takes a stream of raw 12-bit converter samples, each marked by a valid strobe, and turns it into a stream of 32-bit words. A run input enables capture. At the moment run goes high, the block latches its configuration. Capture starts with a one-cycle software trigger pulse. After the trigger, a configurable number of start-up samples is thrown away. Every later sample is then handled in four steps:

- It is cut down to 8, 10 or 12 significant bits.
- It is placed right-aligned in a 16-bit slot.
- It is optionally shifted left.
- It is paired with the next sample to form a word.

Each finished word can have its byte order reversed and its 16-bit halves exchanged. It then leaves on a valid/ready interface. While the output register is full and not accepted, incoming samples are dropped and an overflow flag is raised.

Top module: `sample_formatter`

## Requirements
- R1: After a synchronous reset, `word_vld_o` and `ovf_o` are 0.
- R2: After the trigger, the first N samples are discarded, where N = `cfg_drop_i` + 1 (codes 0..3 give 1..4 samples).
- R3: `cfg_width_i` selects the sample width:
  - 0: 8 bits, taken from raw bits 11:4.
  - 1: 10 bits, taken from raw bits 11:2.
  - 2: all 12 bits.
  - 3: no words are ever output.
  In every width the value is right-aligned in its 16-bit slot.
- R4: In 8-bit mode, `cfg_shift_i` codes 0..4 shift the slot left by that many bits. Codes 5..7 leave it unshifted.
- R5: In 10-bit mode only shift codes 0..2 are applied and other codes give no shift. In 12-bit mode no shift is ever applied.
- R6: The first processed sample of a pair fills bits 15:0 of the packed word and the second fills bits 31:16.
- R7: With `cfg_big_i` = 1, the four bytes of the packed word are reversed (byte 0 goes to bits 31:24).
- R8: With `cfg_hswap_i` = 1, the two halves are exchanged, after any byte reversal.
- R9: Configuration is latched in the cycle run rises. Changes to the configuration inputs while run stays high have no effect.
- R10: While run is high, no sample is accepted until a one-cycle `trig_i` pulse. A single pulse keeps capture enabled until run falls.
- R11: When run falls, the following are all cleared, so a new run starts from an empty pair:
  - the discard count,
  - any half-filled word,
  - the overflow flag.
- R12: While `word_vld_o` is 1 and `word_rdy_i` is 0, the following all hold:
  - `word_o` stays stable,
  - `word_vld_o` stays high,
  - each arriving sample is dropped and sets `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run enable; configuration is latched when it rises |
| trig_i | input | 1 | One-cycle software trigger that starts capture |
| cfg_drop_i | input | 2 | Start-up discard count minus one |
| cfg_width_i | input | 2 | Sample width select (8/10/12/none) |
| cfg_shift_i | input | 3 | Left shift amount |
| cfg_big_i | input | 1 | Reverse byte order of output word |
| cfg_hswap_i | input | 1 | Exchange halfwords of output word |
| smp_i | input | 12 | Raw sample |
| smp_vld_i | input | 1 | Raw sample strobe |
| word_o | output | 32 | Packed output word |
| word_vld_o | output | 1 | Output word valid |
| word_rdy_i | input | 1 | Downstream ready |
| ovf_o | output | 1 | Sticky overflow flag for dropped samples |

## Verification
A table of configurations covers each width with in-range and out-of-range shift codes, each discard count, and every combination of byte reversal and halfword swap. The sample values are chosen so that wrong bit extraction, a missing or extra shift, or a wrong discard count gives a different word. Asymmetric byte patterns tell byte reversal apart from halfword swap, and show the order in which the two are applied. Directed runs check the following:

- Capture before the trigger.
- Configuration changes during a run.
- The no-output width.
- A restart after a half-filled word.
- Back-pressure with a sample dropped, followed by recovery.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    W8   = 2'd0,
    W10  = 2'd1,
    W12  = 2'd2,
    WOFF = 2'd3
  } width_e;

  typedef struct packed {
    logic [1:0] drop;
    width_e     width;
    logic [2:0] shift;
    logic       big;
    logic       hswap;
  } sf_cfg_t;
endpackage

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import sf_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    run_i,
  input  logic    trig_i,
  input  sf_cfg_t cfg_i,
  input  logic    smp_vld_i,
  output sf_cfg_t cfg_o,
  output logic    take_o,
  output logic    clr_o
);
  localparam int CNT_W = 3;

  logic             run_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  sf_cfg_t          cfg_q;
  logic             live;
  logic             in_discard;

  assign live       = active_q && run_i;
  assign in_discard = cnt_q <= {1'b0, cfg_q.drop};
  assign take_o     = live && smp_vld_i && !in_discard;
  assign clr_o      = !run_i;
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      cfg_q    <= '0;
    end else begin
      run_q <= run_i;
      if (!run_q) cfg_q <= cfg_i;
      if (!run_i)      active_q <= 1'b0;
      else if (trig_i) active_q <= 1'b1;
      if (!run_i)
        cnt_q <= '0;
      else if (live && smp_vld_i && in_discard)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: latched configuration does not move while run stays high
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (run_q && run_i) |=> $stable(cfg_q));

  // R2: discard count never passes the configured number of samples
  a_r2_discard_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= {1'b0, cfg_q.drop} + 3'd1);
endmodule

// File: rtl/sf_shape.sv
module sf_shape
  import sf_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int SLOT_W = 16
) (
  input  logic [RAW_W-1:0]  smp_i,
  input  width_e            width_i,
  input  logic [2:0]        shift_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              emit_o
);
  localparam int NARROW = RAW_W - 4;
  localparam int MID    = RAW_W - 2;

  logic [SLOT_W-1:0] base;
  logic [2:0]        amt;

  always_comb begin
    base = SLOT_W'(smp_i);
    amt  = 3'd0;
    unique case (width_i)
      W8: begin
        base = SLOT_W'(smp_i[RAW_W-1 -: NARROW]);
        amt  = (shift_i <= 3'd4) ? shift_i : 3'd0;
      end
      W10: begin
        base = SLOT_W'(smp_i[RAW_W-1 -: MID]);
        amt  = (shift_i <= 3'd2) ? shift_i : 3'd0;
      end
      default: begin
        base = SLOT_W'(smp_i);
        amt  = 3'd0;
      end
    endcase
    slot_o = base << amt;
    emit_o = (width_i != WOFF);
  end
endmodule

// File: rtl/sf_pack.sv
module sf_pack #(
  parameter int SLOT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                take_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                big_i,
  input  logic                hswap_i,
  input  logic                rdy_i,
  output logic [2*SLOT_W-1:0] word_o,
  output logic                vld_o,
  output logic                ovf_o
);
  localparam int WORD_W = 2 * SLOT_W;
  localparam int NB     = WORD_W / 8;

  logic [SLOT_W-1:0] lo_q;
  logic              half_q;
  logic [WORD_W-1:0] word_q;
  logic              vld_q;
  logic              ovf_q;
  logic              full;
  logic [WORD_W-1:0] packed_w;
  logic [WORD_W-1:0] bytes_w;
  logic [WORD_W-1:0] final_w;

  assign full = vld_q && !rdy_i;

  always_comb begin
    packed_w = {slot_i, lo_q};
    for (int i = 0; i < NB; i++)
      bytes_w[i*8 +: 8] = big_i ? packed_w[(NB-1-i)*8 +: 8] : packed_w[i*8 +: 8];
    final_w = hswap_i ? {bytes_w[SLOT_W-1:0], bytes_w[WORD_W-1:SLOT_W]} : bytes_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      half_q <= 1'b0;
      word_q <= '0;
      vld_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (vld_q && rdy_i) vld_q <= 1'b0;
      if (clr_i) begin
        half_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else if (take_i) begin
        if (full) begin
          ovf_q <= 1'b1;
        end else if (!half_q) begin
          lo_q   <= slot_i;
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          word_q <= final_w;
          vld_q  <= 1'b1;
        end
      end
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
  assign ovf_o  = ovf_q;

  // R12: a stalled word holds its value and valid
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !rdy_i) |=> (vld_q && $stable(word_q)));

  // R12: overflow only appears after a cycle with a full output register
  a_r12_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(vld_q && !rdy_i));
endmodule

// File: rtl/sample_formatter.sv
module sample_formatter
  import sf_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int SLOT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic                trig_i,
  input  logic [1:0]          cfg_drop_i,
  input  logic [1:0]          cfg_width_i,
  input  logic [2:0]          cfg_shift_i,
  input  logic                cfg_big_i,
  input  logic                cfg_hswap_i,
  input  logic [RAW_W-1:0]    smp_i,
  input  logic                smp_vld_i,
  output logic [2*SLOT_W-1:0] word_o,
  output logic                word_vld_o,
  input  logic                word_rdy_i,
  output logic                ovf_o
);
  sf_cfg_t           cfg_in;
  sf_cfg_t           cfg_q;
  logic              take;
  logic              clr;
  logic [SLOT_W-1:0] slot;
  logic              emit;

  assign cfg_in = '{drop:  cfg_drop_i,
                    width: width_e'(cfg_width_i),
                    shift: cfg_shift_i,
                    big:   cfg_big_i,
                    hswap: cfg_hswap_i};

  sf_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_i),
    .trig_i    (trig_i),
    .cfg_i     (cfg_in),
    .smp_vld_i (smp_vld_i),
    .cfg_o     (cfg_q),
    .take_o    (take),
    .clr_o     (clr)
  );

  sf_shape #(.RAW_W(RAW_W), .SLOT_W(SLOT_W)) u_shape (
    .smp_i   (smp_i),
    .width_i (cfg_q.width),
    .shift_i (cfg_q.shift),
    .slot_o  (slot),
    .emit_o  (emit)
  );

  sf_pack #(.SLOT_W(SLOT_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .take_i  (take && emit),
    .slot_i  (slot),
    .big_i   (cfg_q.big),
    .hswap_i (cfg_q.hswap),
    .rdy_i   (word_rdy_i),
    .word_o  (word_o),
    .vld_o   (word_vld_o),
    .ovf_o   (ovf_o)
  );
endmodule

// File: tb/sample_formatter_tb.sv
`timescale 1ns/1ps
module sample_formatter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0, trig = 1'b0;
  logic [1:0]  drop = '0, width = 2'd2;
  logic [2:0]  shift = '0;
  logic        big = 1'b0, hsw = 1'b0;
  logic [11:0] smp = '0;
  logic        svld = 1'b0;
  logic [31:0] word;
  logic        wvld, ovf;
  logic        rdy = 1'b1;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sample_formatter u_dut (
    .clk(clk), .rst(rst), .run_i(run), .trig_i(trig),
    .cfg_drop_i(drop), .cfg_width_i(width), .cfg_shift_i(shift),
    .cfg_big_i(big), .cfg_hswap_i(hsw),
    .smp_i(smp), .smp_vld_i(svld),
    .word_o(word), .word_vld_o(wvld), .word_rdy_i(rdy), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [1:0]  d;
    logic [1:0]  w;
    logic [2:0]  s;
    logic        b;
    logic        h;
    logic [11:0] a;
    logic [11:0] c;
    logic [31:0] exp;
  } vec_t;

  // each entry: drop, width, shift, big, hswap, first, second, expected word
  localparam vec_t VEC [0:6] = '{
    '{2'd0, 2'd2, 3'd0, 1'b0, 1'b0, 12'hABC, 12'h123, 32'h0123_0ABC}, // R2 R3 R6
    '{2'd1, 2'd0, 3'd3, 1'b0, 1'b0, 12'hABC, 12'h123, 32'h0090_0558}, // R2 R4
    '{2'd2, 2'd1, 3'd2, 1'b1, 1'b0, 12'hFFF, 12'h801, 32'hFC0F_0008}, // R5 R7
    '{2'd3, 2'd1, 3'd3, 1'b0, 1'b1, 12'h804, 12'h00C, 32'h0201_0003}, // R5 R8
    '{2'd0, 2'd0, 3'd5, 1'b1, 1'b1, 12'h5A0, 12'hC30, 32'hC300_5A00}, // R4 R7 R8
    '{2'd0, 2'd2, 3'd4, 1'b0, 1'b0, 12'hFFF, 12'h000, 32'h0000_0FFF}, // R5
    '{2'd0, 2'd0, 3'd4, 1'b0, 1'b0, 12'hFF0, 12'h010, 32'h0010_0FF0}  // R4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] s);
    @(negedge clk); smp = s; svld = 1'b1;
    @(negedge clk); svld = 1'b0;
  endtask

  task automatic start(input logic [1:0] d, input logic [1:0] w, input logic [2:0] s,
                       input logic b, input logic h);
    @(negedge clk);
    drop = d; width = w; shift = s; big = b; hsw = h;
    run = 1'b1; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk); run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wvld == 1'b0, "R1 valid", 32'(wvld), 32'd0);
    check(ovf == 1'b0, "R1 ovf", 32'(ovf), 32'd0);

    foreach (VEC[i]) begin
      start(VEC[i].d, VEC[i].w, VEC[i].s, VEC[i].b, VEC[i].h);
      for (int k = 0; k <= int'(VEC[i].d); k++) send(12'h777);
      send(VEC[i].a);
      send(VEC[i].c);
      check(wvld == 1'b1, "R6 vector valid", 32'(wvld), 32'd1);
      check(word == VEC[i].exp, "R2-R8 vector word", word, VEC[i].exp);
      stop();
    end

    // R10: no capture before the trigger
    @(negedge clk);
    drop = 2'd0; width = 2'd2; shift = 3'd0; big = 1'b0; hsw = 1'b0; run = 1'b1;
    for (int k = 0; k < 4; k++) begin
      send(12'h111);
      check(wvld == 1'b0, "R10 pre-trigger", 32'(wvld), 32'd0);
    end
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    send(12'h777);
    send(12'h0AA);
    send(12'h055);
    check(wvld && word == 32'h0055_00AA, "R10 after trigger", word, 32'h0055_00AA);
    stop();

    // R9: configuration changes during a run are ignored
    start(2'd0, 2'd2, 3'd0, 1'b0, 1'b0);
    @(negedge clk); drop = 2'd3; width = 2'd0; shift = 3'd4; big = 1'b1; hsw = 1'b1;
    send(12'h777);
    send(12'h123);
    send(12'h456);
    check(wvld && word == 32'h0456_0123, "R9 latched cfg", word, 32'h0456_0123);
    stop();

    // R3: width code 3 never emits
    start(2'd0, 2'd3, 3'd0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      send(12'hF0F);
      check(wvld == 1'b0, "R3 no output", 32'(wvld), 32'd0);
    end
    stop();

    // R11: stop clears half word and discard count
    start(2'd1, 2'd2, 3'd0, 1'b0, 1'b0);
    send(12'h777); send(12'h777); send(12'h999);
    stop();
    start(2'd0, 2'd2, 3'd0, 1'b0, 1'b0);
    send(12'h777);
    send(12'h0A1);
    send(12'h0B2);
    check(wvld && word == 32'h00B2_00A1, "R11 restart", word, 32'h00B2_00A1);
    stop();

    // R12: back-pressure
    start(2'd0, 2'd2, 3'd0, 1'b0, 1'b0);
    rdy = 1'b0;
    send(12'h777); send(12'h001); send(12'h002);
    check(wvld && word == 32'h0002_0001, "R12 stalled word", word, 32'h0002_0001);
    send(12'h003);
    check(ovf == 1'b1, "R12 ovf set", 32'(ovf), 32'd1);
    check(wvld && word == 32'h0002_0001, "R12 word held", word, 32'h0002_0001);
    rdy = 1'b1;
    @(negedge clk);
    check(wvld == 1'b0, "R12 drained", 32'(wvld), 32'd0);
    send(12'h004); send(12'h005);
    check(wvld && word == 32'h0005_0004, "R12 recovery", word, 32'h0005_0004);
    stop();
    check(ovf == 1'b0, "R11 ovf cleared", 32'(ovf), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule